// File: doc/BRIEF.md
# Torus Minimal Route Unit

This block is the route-computation stage of a router for a three-dimensional torus. The router has six network directions, plus injection and ejection ports. The header of each packet carries six hint bits, one per direction, and a set bit means the packet still has hops to take that way. The unit turns those hints into three results:

- a mask of candidate outputs for the adaptive virtual channels;
- a single dimension-ordered direction for the escape channel, with a buffer-room check that keeps that channel deadlock-free;
- a refreshed copy of the hints for the next node.

A broadcast packet is handled in the same stage. It travels along one dimension, is delivered locally at every node it passes, and is forwarded until the hop count in its header is spent.

Each accepted header produces one registered result, one clock later. The neighbour coordinates and the free space of each downstream escape buffer are level inputs held by the surrounding router. Arbitration and buffering are done elsewhere.

Top module: `torus_route_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after `in_valid` was sampled high. After reset, all outputs are zero.
- R2: A header with both bits of any dimension pair set is flagged as an error. The same error is raised for a broadcast header whose hint count is not exactly one. An error result has zero candidates, no ejection, no escape direction and no escape permission.
- R3: For a valid, non-broadcast header with at least one hint set, the candidate mask equals the hints. The hint bit order is 0=+X, 1=-X, 2=+Y, 3=-Y, 4=+Z, 5=-Z.
- R4: The escape direction is the lowest-numbered set candidate bit, which gives X before Y before Z. `out_esc_valid` is high exactly when the candidate mask is non-zero.
- R5: Escape permission (`out_esc_ok`) requires a valid escape direction and enough free tokens in that direction's downstream buffer. If the escape direction's dimension (direction index divided by 2) equals `in_dim`, the buffer needs `MAX_PKT_TOK` free tokens. Otherwise it needs twice that. `in_dim` = 3 means injection, which never matches a dimension.
- R6: Bit d of `out_last_hop` is set when hint d is set and neighbour coordinate d equals the destination coordinate of dimension d/2. For a non-broadcast packet whose escape bit is a last hop, that bit is cleared in `out_hints`. In every other case `out_hints` equals the input hints.
- R7: A valid, non-broadcast header with all hints clear is ejected, with zero candidates.
- R8: A valid broadcast header is always ejected. When its hop count is non-zero it is also forwarded along its single hinted direction, and `out_hops` is one less than the input. When the hop count is zero it has no candidates. Non-broadcast packets pass the hop count through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header present this cycle |
| in_hints | input | 6 | Remaining-direction hint bits |
| in_dest | input | 3*CW | Destination coordinates, X in the low field |
| in_bcast | input | 1 | Header is a single-dimension broadcast |
| in_hops | input | HW | Broadcast hops remaining |
| in_dim | input | 2 | Dimension the packet arrived on, 3 = injection |
| nbr_coord | input | 6*CW | Coordinate of the neighbour in each direction |
| esc_free | input | 6*FW | Free tokens in each downstream escape buffer |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Malformed header |
| out_cand | output | 6 | Adaptive candidate directions |
| out_esc_valid | output | 1 | Escape direction is meaningful |
| out_esc_dir | output | 3 | Escape direction index |
| out_esc_ok | output | 1 | Escape bubble rule satisfied |
| out_eject | output | 1 | Deliver to the local node |
| out_last_hop | output | 6 | Directions whose next hop reaches the destination coordinate |
| out_hints | output | 6 | Hints for the next node |
| out_hops | output | HW | Updated broadcast hop count |

## Verification
Broadcast forwarding and local ejection can fall in the same result. The bench sweeps every hint pattern with hop counts 0, 1 and 2, so a packet on its final forwarded hop has to show ejection, a one-hot candidate and a hop count of zero all at once. The escape direction, its last-hop clearing and the bubble check also land together. Varying the arrival dimension and the free-token counts on the same vectors puts the same-dimension and new-dimension thresholds beside a hint that is being cleared.

// File: rtl/torus_rt_pkg.sv
package torus_rt_pkg;
  localparam int NDIR = 6;
  localparam int NDIM = 3;
  typedef logic [NDIR-1:0] dir_mask_t;
  typedef logic [2:0]      dir_idx_t;
endpackage

// File: rtl/tr_hint_decode.sv
module tr_hint_decode
  import torus_rt_pkg::*;
(
  input  dir_mask_t hints,
  input  logic      bcast,
  input  logic      hops_zero,
  output logic      err,
  output dir_mask_t cand,
  output logic      eject,
  output logic      esc_valid,
  output dir_idx_t  esc_dir
);
  logic [NDIM-1:0] pair_bad;
  logic            bcast_bad;

  genvar k;
  generate
    for (k = 0; k < NDIM; k++) begin : g_pair
      assign pair_bad[k] = hints[2*k] & hints[2*k+1];
    end
  endgenerate

  assign bcast_bad = bcast && ($countones(hints) != 1);
  assign err       = (|pair_bad) || bcast_bad;

  always_comb begin
    cand  = '0;
    eject = 1'b0;
    if (!err) begin
      if (bcast) begin
        eject = 1'b1;
        cand  = hops_zero ? '0 : hints;
      end else if (hints == '0) begin
        eject = 1'b1;
      end else begin
        cand = hints;
      end
    end
  end

  always_comb begin
    esc_dir = '0;
    for (int d = NDIR - 1; d >= 0; d--) begin
      if (cand[d]) esc_dir = 3'(d);
    end
  end
  assign esc_valid = |cand;
endmodule

// File: rtl/tr_bubble_check.sv
module tr_bubble_check
  import torus_rt_pkg::*;
#(
  parameter int FW          = 5,
  parameter int MAX_PKT_TOK = 8
) (
  input  logic [NDIR*FW-1:0] free_flat,
  input  dir_idx_t           esc_dir,
  input  logic               esc_valid,
  input  logic [1:0]         in_dim,
  output logic               ok
);
  localparam int NEED_SAME = MAX_PKT_TOK;
  localparam int NEED_NEW  = 2 * MAX_PKT_TOK;

  logic [FW-1:0] sel_free;
  logic          same_dim;

  always_comb begin
    sel_free = '0;
    for (int d = 0; d < NDIR; d++) begin
      if (esc_dir == 3'(d)) sel_free = free_flat[d*FW +: FW];
    end
  end

  assign same_dim = (esc_dir[2:1] == in_dim);
  assign ok = esc_valid &&
              (int'(sel_free) >= (same_dim ? NEED_SAME : NEED_NEW));
endmodule

// File: rtl/tr_hop_update.sv
module tr_hop_update
  import torus_rt_pkg::*;
#(
  parameter int CW = 4,
  parameter int HW = 4
) (
  input  dir_mask_t           hints,
  input  logic [NDIM*CW-1:0]  dest_flat,
  input  logic [NDIR*CW-1:0]  nbr_flat,
  input  logic                bcast,
  input  logic                esc_valid,
  input  dir_idx_t            esc_dir,
  input  logic [HW-1:0]       hops,
  output dir_mask_t           last_hop,
  output dir_mask_t           hints_next,
  output logic [HW-1:0]       hops_next
);
  genvar d;
  generate
    for (d = 0; d < NDIR; d++) begin : g_last
      assign last_hop[d] = hints[d] &&
        (nbr_flat[d*CW +: CW] == dest_flat[(d/2)*CW +: CW]);
    end
  endgenerate

  always_comb begin
    hints_next = hints;
    if (!bcast && esc_valid && last_hop[esc_dir]) hints_next[esc_dir] = 1'b0;
  end

  assign hops_next = (bcast && hops != '0) ? hops - 1'b1 : hops;
endmodule

// File: rtl/torus_route_unit.sv
module torus_route_unit
  import torus_rt_pkg::*;
#(
  parameter int CW          = 4,
  parameter int HW          = 4,
  parameter int FW          = 5,
  parameter int MAX_PKT_TOK = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [5:0]          in_hints,
  input  logic [3*CW-1:0]     in_dest,
  input  logic                in_bcast,
  input  logic [HW-1:0]       in_hops,
  input  logic [1:0]          in_dim,
  input  logic [6*CW-1:0]     nbr_coord,
  input  logic [6*FW-1:0]     esc_free,
  output logic                out_valid,
  output logic                out_err,
  output logic [5:0]          out_cand,
  output logic                out_esc_valid,
  output logic [2:0]          out_esc_dir,
  output logic                out_esc_ok,
  output logic                out_eject,
  output logic [5:0]          out_last_hop,
  output logic [5:0]          out_hints,
  output logic [HW-1:0]       out_hops
);
  logic          c_err, c_eject, c_esc_valid, c_ok;
  dir_mask_t     c_cand, c_last, c_hints;
  dir_idx_t      c_dir;
  logic [HW-1:0] c_hops;

  tr_hint_decode u_dec (
    .hints(in_hints), .bcast(in_bcast), .hops_zero(in_hops == '0),
    .err(c_err), .cand(c_cand), .eject(c_eject),
    .esc_valid(c_esc_valid), .esc_dir(c_dir)
  );

  tr_bubble_check #(.FW(FW), .MAX_PKT_TOK(MAX_PKT_TOK)) u_bub (
    .free_flat(esc_free), .esc_dir(c_dir), .esc_valid(c_esc_valid),
    .in_dim(in_dim), .ok(c_ok)
  );

  tr_hop_update #(.CW(CW), .HW(HW)) u_hop (
    .hints(in_hints), .dest_flat(in_dest), .nbr_flat(nbr_coord),
    .bcast(in_bcast), .esc_valid(c_esc_valid), .esc_dir(c_dir),
    .hops(in_hops), .last_hop(c_last), .hints_next(c_hints),
    .hops_next(c_hops)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      out_err       <= 1'b0;
      out_cand      <= '0;
      out_esc_valid <= 1'b0;
      out_esc_dir   <= '0;
      out_esc_ok    <= 1'b0;
      out_eject     <= 1'b0;
      out_last_hop  <= '0;
      out_hints     <= '0;
      out_hops      <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_err       <= c_err;
        out_cand      <= c_cand;
        out_esc_valid <= c_esc_valid;
        out_esc_dir   <= c_dir;
        out_esc_ok    <= c_ok;
        out_eject     <= c_eject;
        out_last_hop  <= c_last;
        out_hints     <= c_hints;
        out_hops      <= c_hops;
      end
    end
  end

  // R1: one registered result per accepted header
  a_r1_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R2: a malformed header produces no routing
  a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_cand == '0 && !out_eject && !out_esc_valid && !out_esc_ok));
  // R4: the escape direction is one of the candidates
  a_r4_esc_in_cand: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_esc_valid) |-> out_cand[out_esc_dir]);
  // R5: permission needs a direction
  a_r5_ok_needs_esc: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_esc_ok) |-> out_esc_valid);
  // R6: last hops come only from hints that were set
  a_r6_last_subset: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_last_hop & ~$past(in_hints)) == '0));
  // R8: a forwarded ejecting packet has one candidate
  a_r8_bcast_single: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eject && out_cand != '0) |-> ($countones(out_cand) == 1));
endmodule

// File: tb/torus_route_unit_tb.sv
module torus_route_unit_tb;
  localparam int CW = 4, HW = 4, FW = 5, MAXT = 8;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_bcast = 1'b0;
  logic [5:0] in_hints = '0;
  logic [3*CW-1:0] in_dest = '0;
  logic [HW-1:0] in_hops = '0;
  logic [1:0] in_dim = '0;
  logic [6*CW-1:0] nbr_coord;
  logic [6*FW-1:0] esc_free = '0;
  logic out_valid, out_err, out_esc_valid, out_esc_ok, out_eject;
  logic [5:0] out_cand, out_last_hop, out_hints;
  logic [2:0] out_esc_dir;
  logic [HW-1:0] out_hops;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  torus_route_unit #(.CW(CW), .HW(HW), .FW(FW), .MAX_PKT_TOK(MAXT)) u_dut (
    .clk, .rst, .in_valid, .in_hints, .in_dest, .in_bcast, .in_hops, .in_dim,
    .nbr_coord, .esc_free, .out_valid, .out_err, .out_cand, .out_esc_valid,
    .out_esc_dir, .out_esc_ok, .out_eject, .out_last_hop, .out_hints, .out_hops
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // neighbour in direction d sits at coordinate d+1
  initial for (int d = 0; d < 6; d++) nbr_coord[d*CW +: CW] = 4'(d + 1);

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    chk(out_cand == '0 && out_hints == '0, "R1 reset data", int'(out_cand), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 idle valid", int'(out_valid), 0);

    for (int h = 0; h < 64; h++)
      for (int bc = 0; bc < 2; bc++)
        for (int dm = 0; dm < 4; dm++)
          for (int m = 0; m < 27; m++) begin
            int dsel[3];
            int dest[3];
            int hops, cnt, ecand, edir, eescv, eok, elast, ehints, ehops, need, fr;
            bit pair, eerr, eej;
            dsel[0] = m % 3; dsel[1] = (m / 3) % 3; dsel[2] = m / 9;
            for (int k = 0; k < 3; k++)
              dest[k] = (dsel[k] == 0) ? 2*k + 1 : (dsel[k] == 1) ? 2*k + 2 : 15;
            hops = (m + h) % 3;
            in_valid = 1'b1;
            in_hints = 6'(h);
            in_bcast = bc[0];
            in_dim = 2'(dm);
            in_hops = 4'(hops);
            for (int k = 0; k < 3; k++) in_dest[k*CW +: CW] = 4'(dest[k]);
            for (int d = 0; d < 6; d++) esc_free[d*FW +: FW] = 5'((h + m*3 + d*5 + dm) % 32);
            // expected values
            pair = 1'b0; cnt = 0;
            for (int k = 0; k < 3; k++) if (h[2*k] && h[2*k+1]) pair = 1'b1;
            for (int d = 0; d < 6; d++) if (h[d]) cnt++;
            eerr = pair || (bc == 1 && cnt != 1);
            if (eerr) ecand = 0;
            else if (bc == 1) ecand = (hops == 0) ? 0 : h;
            else ecand = h;
            eej = !eerr && (bc == 1 || h == 0);
            eescv = (ecand != 0);
            edir = 0;
            for (int d = 5; d >= 0; d--) if (ecand[d]) edir = d;
            need = (edir / 2 == dm) ? MAXT : 2 * MAXT;
            fr = (h + m*3 + edir*5 + dm) % 32;
            eok = (eescv && fr >= need) ? 1 : 0;
            elast = 0;
            for (int d = 0; d < 6; d++) if (h[d] && (d + 1) == dest[d/2]) elast |= (1 << d);
            ehints = h;
            if (bc == 0 && eescv && elast[edir]) ehints &= ~(1 << edir);
            ehops = (bc == 1 && hops != 0) ? hops - 1 : hops;
            @(negedge clk);
            chk(out_valid == 1'b1, "R1 valid", int'(out_valid), 1);
            chk(out_err == eerr, "R2 error flag", int'(out_err), int'(eerr));
            chk(int'(out_cand) == ecand, (bc == 1) ? "R8 bcast cand" : "R3 cand", int'(out_cand), ecand);
            chk(out_eject == eej, (bc == 1) ? "R8 eject" : "R7 eject", int'(out_eject), int'(eej));
            chk(int'(out_esc_valid) == eescv, "R4 esc valid", int'(out_esc_valid), eescv);
            if (eescv) chk(int'(out_esc_dir) == edir, "R4 esc dir", int'(out_esc_dir), edir);
            chk(int'(out_esc_ok) == eok, "R5 bubble", int'(out_esc_ok), eok);
            chk(int'(out_last_hop) == elast, "R6 last hop", int'(out_last_hop), elast);
            chk(int'(out_hints) == ehints, "R6 hints next", int'(out_hints), ehints);
            chk(int'(out_hops) == ehops, "R8 hops", int'(out_hops), ehops);
          end

    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 drain", int'(out_valid), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule